// File: doc/BRIEF.md
# Truncated Constant-Coefficient FIR Filter

This block is a direct-form FIR filter with a fixed set of signed integer coefficients. Each accepted input sample enters a tapped delay line. The filter then multiplies every stored sample by its own constant coefficient and sums the products into one fixed-width output. The partial products are not summed tap by tap. Every set bit of every coefficient contributes one shifted row of the sample it weights, and all of these rows from all taps are added together in a single shared summation.

Partial-product bits below a parameterised column are discarded before the summation. A single constant is added to the sum to make up for these discarded bits. The same constant also carries the offsets that make the signed rows unsigned and the half-LSB used for rounding. The output is the sum scaled down by 2^FRAC_SHIFT and reduced to OUT_W bits, with an error of less than one output LSB.

Each coefficient may have its own bit width, so narrow coefficients produce fewer rows. A pulse on `in_valid` yields exactly one pulse on `out_valid` two clock edges later.

Top module: `trunc_mcma_fir`

## Requirements
- R1: On a rising edge with `in_valid` high and reset low, the newest delay-line stage takes `in_sample`, and every older stage takes the value of the stage before it. The output for that sample is based on the delay line after this shift, with stage 0 holding the newest sample.
- R2: Let S be the sum over all taps of COEF[i]·x[n−i], where samples before reset count as 0. For every produced output y, |y·2^FRAC_SHIFT − S| < 2^FRAC_SHIFT, so the error is less than one output LSB.
- R3: `out_valid` is high for exactly one cycle for each accepted sample, two rising edges after the edge that sampled `in_valid`. Outputs appear in the order of the samples.
- R4: When `in_valid` is low, the delay line is unchanged and no output is produced. While `out_valid` is low, `out_sample` keeps its last value.
- R5: A synchronous active-high `rst` clears the delay line, `out_valid` and `out_sample` to zero. After reset, outputs behave as if all earlier samples were zero.
- R6: R2 still holds at full scale: for inputs of +2047 and −2048, for sequences that alternate between them, and with negative coefficients of different widths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is valid this cycle |
| in_sample | input | IN_W | Signed two's-complement input sample |
| out_valid | output | 1 | Output sample is valid this cycle |
| out_sample | output | OUT_W | Signed filtered output, faithfully rounded |

## Verification
The assertions check the cycle-level behaviour on every cycle:
- the delay line loads and shifts on an accepted sample;
- the delay line holds when no sample is accepted;
- the valid signal moves through both register stages;
- the output holds between valid pulses;
- the reset state is cleared.

Arithmetic accuracy can only be shown by the bench scenarios. A scoreboard compares every output against a full-precision reference sum for impulses of both signs, sustained full-scale inputs, alternating extremes and random streams with and without gaps. A reset in the middle of a stream checks that earlier samples are forgotten.

// File: rtl/fir_pkg.sv
package fir_pkg;

  // Bit j of a signed coefficient value
  function automatic bit coef_bit(int c, int j);
    return ((c >>> j) & 1) == 1;
  endfunction

  // Constant offset that turns row j into an unsigned offset-binary row.
  // A positive row adds x*2^j with x = u - 2^(in_w-1).
  // The sign row adds -x*2^j = ~u*2^j - (2^in_w - 1)*2^j + 2^(in_w-1+j).
  function automatic longint row_const(int cw, int j, int in_w);
    longint half;
    half = longint'(1) <<< (in_w - 1 + j);
    if (j == cw - 1)
      return half - (((longint'(1) <<< in_w) - 1) <<< j);
    else
      return -half;
  endfunction

  // Largest total weight of row-j bits that sit below column tcol
  function automatic longint row_drop(int j, int in_w, int tcol);
    longint d;
    d = 0;
    for (int k = 0; k < in_w; k++)
      if (j + k < tcol) d += longint'(1) <<< (j + k);
    return d;
  endfunction

endpackage

// File: rtl/fir_tap_line.sv
module fir_tap_line #(
  parameter int NTAP = 8,
  parameter int IN_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_sample,
  output logic signed [IN_W-1:0] taps [NTAP],
  output logic                   stg_vld
);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAP; i++) taps[i] <= '0;
      stg_vld <= 1'b0;
    end else begin
      stg_vld <= in_valid;
      if (in_valid) begin
        taps[0] <= in_sample;
        for (int i = 1; i < NTAP; i++) taps[i] <= taps[i-1];
      end
    end
  end

endmodule

// File: rtl/fir_pp_rows.sv
module fir_pp_rows #(
  parameter int NTAP      = 8,
  parameter int IN_W      = 12,
  parameter int COEF_W    = 12,
  parameter int ACC_W     = 26,
  parameter int TRUNC_COL = 5,
  parameter int COEF [NTAP] = '{default: 0},
  parameter int CWID [NTAP] = '{default: 1}
) (
  input  logic signed [IN_W-1:0]  taps [NTAP],
  output logic        [ACC_W-1:0] rows [NTAP*COEF_W]
);

  localparam logic [ACC_W-1:0] KEEP = {ACC_W{1'b1}} << TRUNC_COL;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    logic [IN_W-1:0] ob;
    assign ob = {~taps[i][IN_W-1], taps[i][IN_W-2:0]};

    for (genvar j = 0; j < COEF_W; j++) begin : g_bit
      if (j < CWID[i] && fir_pkg::coef_bit(COEF[i], j)) begin : g_on
        localparam bit NEG = (j == CWID[i] - 1);
        logic [IN_W-1:0] opnd;
        assign opnd = NEG ? ~ob : ob;
        assign rows[i*COEF_W+j] = (ACC_W'(opnd) << j) & KEEP;
      end else begin : g_off
        assign rows[i*COEF_W+j] = '0;
      end
    end
  end

endmodule

// File: rtl/fir_compress.sv
module fir_compress #(
  parameter int NROW       = 96,
  parameter int ACC_W      = 26,
  parameter int FRAC_SHIFT = 10,
  parameter int OUT_W      = 16,
  parameter logic [ACC_W-1:0] CORR = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stg_vld,
  input  logic [ACC_W-1:0]        rows [NROW],
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_sample
);

  logic [ACC_W-1:0] acc;

  always_comb begin
    acc = CORR;
    for (int r = 0; r < NROW; r++) acc = acc + rows[r];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= stg_vld;
      if (stg_vld) out_sample <= OUT_W'(acc >> FRAC_SHIFT);
    end
  end

endmodule

// File: rtl/trunc_mcma_fir.sv
module trunc_mcma_fir #(
  parameter int NTAP       = 8,
  parameter int IN_W       = 12,
  parameter int COEF_W     = 12,
  parameter int OUT_W      = 16,
  parameter int FRAC_SHIFT = 10,
  parameter int TRUNC_COL  = 5,
  parameter int COEF [NTAP] = '{-75, 203, -411, 1530, 1530, -411, 203, -75},
  parameter int CWID [NTAP] = '{8, 9, 10, 12, 12, 10, 9, 8}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_sample,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_sample
);

  localparam int ACC_W = FRAC_SHIFT + OUT_W;
  localparam int NROW  = NTAP * COEF_W;

  // Offsets of all rows, plus the rounding half-LSB, plus the mean of the dropped bits
  function automatic longint total_corr();
    longint k, d;
    k = 0;
    d = 0;
    for (int i = 0; i < NTAP; i++)
      for (int j = 0; j < COEF_W; j++)
        if (j < CWID[i] && fir_pkg::coef_bit(COEF[i], j)) begin
          k += fir_pkg::row_const(CWID[i], j, IN_W);
          d += fir_pkg::row_drop(j, IN_W, TRUNC_COL);
        end
    return k + (longint'(1) <<< (FRAC_SHIFT - 1)) + d / 2;
  endfunction

  localparam longint           CORR_L = total_corr();
  localparam logic [ACC_W-1:0] CORR_V = CORR_L[ACC_W-1:0];

  logic signed [IN_W-1:0] taps [NTAP];
  logic                   stg_vld;
  logic [ACC_W-1:0]       rows [NROW];

  // Delay-line stages exposed for the checker
  logic signed [IN_W-1:0] tap_newest, tap_next;
  assign tap_newest = taps[0];
  assign tap_next   = taps[1];

  fir_tap_line #(.NTAP(NTAP), .IN_W(IN_W)) u_line (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .taps(taps), .stg_vld(stg_vld)
  );

  fir_pp_rows #(
    .NTAP(NTAP), .IN_W(IN_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
    .TRUNC_COL(TRUNC_COL), .COEF(COEF), .CWID(CWID)
  ) u_rows (
    .taps(taps), .rows(rows)
  );

  fir_compress #(
    .NROW(NROW), .ACC_W(ACC_W), .FRAC_SHIFT(FRAC_SHIFT), .OUT_W(OUT_W), .CORR(CORR_V)
  ) u_comp (
    .clk(clk), .rst(rst), .stg_vld(stg_vld), .rows(rows),
    .out_valid(out_valid), .out_sample(out_sample)
  );

endmodule

// File: rtl/fir_chk.sv
module fir_chk #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic signed [IN_W-1:0]  in_sample,
  input logic                    stg_vld,
  input logic signed [IN_W-1:0]  tap_newest,
  input logic signed [IN_W-1:0]  tap_next,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_sample
);

  AST_TAP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |-> tap_newest == $past(in_sample)); // R1
  AST_TAP_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |-> tap_next == $past(tap_newest)); // R1
  AST_TAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> ($stable(tap_newest) && $stable(tap_next))); // R4
  AST_STAGE_VALID: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stg_vld == $past(in_valid)); // R3
  AST_OUT_VALID: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(stg_vld)); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !out_valid) |-> $stable(out_sample)); // R4
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_sample == '0 && tap_newest == '0)); // R5

endmodule

bind trunc_mcma_fir fir_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
  .stg_vld(stg_vld), .tap_newest(tap_newest), .tap_next(tap_next),
  .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/sim_trunc_mcma_fir.sv
module sim_trunc_mcma_fir;

  localparam int NT = 8;
  localparam int SCALE = 1024;
  localparam int C [NT] = '{-75, 203, -411, 1530, 1530, -411, 203, -75};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [11:0] in_sample = '0;
  logic out_valid;
  logic signed [15:0] out_sample;

  always #2.5 clk = ~clk;

  trunc_mcma_fir u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  int n_chk = 0;
  int n_err = 0;
  longint exp_q [$];
  int hist [NT];
  logic h1 = 1'b0, h2 = 1'b0;
  longint last_out = 0;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Driver: present one sample and push its reference sum
  task automatic send(int x);
    longint s;
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_sample = 12'(x);
    for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    s = 0;
    for (int i = 0; i < NT; i++) s += longint'(C[i]) * hist[i];
    exp_q.push_back(s);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_sample = 12'h5A5;
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    in_valid = 1'b0;
    for (int i = 0; i < NT; i++) hist[i] = 0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // Monitor: latency, hold and scoreboard comparison
  always @(negedge clk) begin
    if (rst) begin
      h1 = 1'b0; h2 = 1'b0; last_out = 0;
    end else begin
      check(out_valid == h2, "R3 out_valid latency", longint'(out_valid), longint'(h2));
      h2 = h1;
      h1 = in_valid;
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 output without sample", longint'(out_sample), 0);
        end else begin
          longint e, d;
          e = exp_q.pop_front();
          d = longint'(out_sample) * SCALE - e;
          check(d > -SCALE && d < SCALE, "R2/R6 faithful result",
                longint'(out_sample) * SCALE, e);
        end
        last_out = longint'(out_sample);
      end else begin
        check(longint'(out_sample) == last_out, "R4 output hold",
              longint'(out_sample), last_out);
      end
    end
  end

  initial begin
    for (int i = 0; i < NT; i++) hist[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R5 reset out_valid", longint'(out_valid), 0);
    check(out_sample == 0, "R5 reset out_sample", longint'(out_sample), 0);

    // R1: positive impulse walks through every tap
    send(2047);
    for (int k = 0; k < 9; k++) send(0);
    idle(4);
    // R4: negative impulse with idle gaps, delay line must hold in gaps
    send(-2048);
    for (int k = 0; k < 9; k++) begin idle(3); send(0); end
    idle(4);
    // R6: sustained full-scale of both signs and alternating extremes
    for (int k = 0; k < 10; k++) send(2047);
    for (int k = 0; k < 10; k++) send(-2048);
    for (int k = 0; k < 16; k++) send((k % 2 == 0) ? 2047 : -2048);
    idle(4);
    // R2: random contiguous stream, then random stream with gaps
    for (int k = 0; k < 300; k++) send(int'($urandom_range(0, 4095)) - 2048);
    for (int k = 0; k < 100; k++) begin
      send(int'($urandom_range(0, 4095)) - 2048);
      idle(int'($urandom_range(0, 3)));
    end
    idle(4);
    // R5: reset mid-history, then impulse must see zero history
    for (int k = 0; k < 5; k++) send(1500);
    idle(4);
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R5 mid reset out_valid", longint'(out_valid), 0);
    check(out_sample == 0, "R5 mid reset out_sample", longint'(out_sample), 0);
    send(-1234);
    for (int k = 0; k < 8; k++) send(0);
    idle(5);
    check(exp_q.size() == 0, "R3 one output per sample", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule